// File: doc/BRIEF.md
# PRBS Link Self-Test Checker

This block is the receive-side self-test for a link that delivers one 24-bit parallel word per clock. With the test enable low it is transparent: each received word appears on the output bus one cycle later. With the test enable high and the lock input asserted, received words are no longer passed on. The block instead compares each one against a locally generated PRBS-7 sequence and reports the result on the same output bus.

The checker is enabled first, and the remote pattern source is started after it. Idle words are skipped. The first word that carries pattern content seeds the local generator, so no alignment handshake is needed. A mode input selects what the output bus shows: either per-bit mismatch flags for every compared word, or a saturating count of mismatching words. A pass flag rises once a fixed-length run of compared words has finished with no mismatch while lock stayed high.

Top module: `link_bist_checker`

## Requirements
- R1: A synchronous active-high reset drives the output bus to zero and the pass flag low.
- R2: While `test_en` is low, the output bus equals the received word of the previous cycle, and the pass flag is low.
- R3: While testing is active and the checker is not yet synchronised, a word whose bits [6:0] are all zero counts as idle. That cycle the output bus is zero, and no seeding takes place. The first word with a nonzero bits [6:0] seeds the generator. That word is not compared, and its cycle also shows zero on the output bus.
- R4: The expected stream obeys b[n] = b[n-7] XOR b[n-6] (polynomial x^7 + x^6 + 1). It is packed 24 bits per word, bit 23 earliest and bit 0 latest. The seed state is the seed word's bits [6:0], with bit 6 the oldest.
- R5: With `err_mode` low, output bit i one cycle after a compared word is high exactly when received bit i differed from expected bit i.
- R6: With `err_mode` high, output bits [7:0] one cycle after each word show the number of compared words since seeding that had at least one mismatching bit. The count saturates at 255, and bits [23:8] are zero. The count advances whichever mode is selected.
- R7: A mismatching word does not shift the expected sequence; later correct words compare clean.
- R8: The pass flag rises one cycle after the RUN_LEN-th compared word (default 1024) if none of those words mismatched. It stays low otherwise. Once high, it holds until testing stops.
- R9: Dropping `lock` or `test_en` clears the count, the pass flag and the synchronisation. While `test_en` is high and `lock` is low, the output bus is zero and the pass flag is low.
- R10: The checker synchronises to any starting phase of the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock, one word per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | High selects self-test, low selects normal pass-through |
| lock | input | 1 | Receiver lock indication; the test is live only while high |
| err_mode | input | 1 | 0: per-bit mismatch flags, 1: saturating mismatch count |
| rx_word | input | 24 | Received parallel word |
| out_bus | output | 24 | Received data, mismatch flags or count, registered |
| pass | output | 1 | High after a clean, complete run under lock |

## Verification
Words from an independent sequence model are sent with error masks drawn at random, together with directed masks: all bits wrong, only the first bit, only the last bit. Matching the flags to the masks confirms the bit order and shows that errors do not shift the expected stream. Idle words with garbage above bit 6, new random starting phases and lock drops check seeding and clearing. One run saturates the count past 255. Two full-length runs, one clean and one with a single bad word, tell a correct pass decision from an early, late or missing one.

// File: rtl/link_bist_pkg.sv
package link_bist_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } bist_state_e;

endpackage

// File: rtl/bist_prbs_step.sv
// Advances a Fibonacci LFSR (x^ORD + x^TAP + 1) by WORD_W bits in one cycle.
// The first generated bit lands on the word's MSB.
module bist_prbs_step #(
  parameter int WORD_W = 24,
  parameter int ORD    = 7,
  parameter int TAP    = 6
) (
  input  logic [ORD-1:0]    state_i,
  output logic [WORD_W-1:0] word_o,
  output logic [ORD-1:0]    state_o
);

  logic [ORD-1:0] sr;
  logic           nb;

  always_comb begin
    sr     = state_i;
    nb     = 1'b0;
    word_o = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      nb        = sr[ORD-1] ^ sr[TAP-1];
      word_o[i] = nb;
      sr        = {sr[ORD-2:0], nb};
    end
    state_o = sr;
  end

endmodule

// File: rtl/bist_sync.sv
// Hunts for the first pattern word, seeds the local LFSR from it, then
// produces one expected word per clock and tracks the run length.
module bist_sync
  import link_bist_pkg::*;
#(
  parameter int WORD_W  = 24,
  parameter int ORD     = 7,
  parameter int TAP     = 6,
  parameter int RUN_LEN = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic [WORD_W-1:0] rx_word,
  output logic              cmp_valid,
  output logic              last_word,
  output logic [WORD_W-1:0] exp_word
);

  localparam int RUN_W = $clog2(RUN_LEN + 1);

  bist_state_e    st_q;
  logic [ORD-1:0] lfsr_q;
  logic [ORD-1:0] lfsr_adv;
  logic [RUN_W-1:0] run_q;
  logic           seed_now;

  bist_prbs_step #(
    .WORD_W (WORD_W),
    .ORD    (ORD),
    .TAP    (TAP)
  ) u_step (
    .state_i (lfsr_q),
    .word_o  (exp_word),
    .state_o (lfsr_adv)
  );

  assign seed_now  = active && (st_q == ST_HUNT) && (rx_word[ORD-1:0] != '0);
  assign cmp_valid = active && ((st_q == ST_RUN) || (st_q == ST_DONE));
  assign last_word = active && (st_q == ST_RUN) && (run_q == RUN_W'(RUN_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      st_q   <= ST_HUNT;
      lfsr_q <= '0;
      run_q  <= '0;
    end else if (seed_now) begin
      st_q   <= ST_RUN;
      lfsr_q <= rx_word[ORD-1:0];
      run_q  <= '0;
    end else if (cmp_valid) begin
      lfsr_q <= lfsr_adv;
      if (st_q == ST_RUN) begin
        if (last_word) st_q <= ST_DONE;
        else           run_q <= run_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bist_err_acc.sv
// Forms the per-bit mismatch vector, keeps the saturating count of bad
// words and decides the pass flag at the end of a run.
module bist_err_acc #(
  parameter int WORD_W = 24,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              cmp_valid,
  input  logic              last_word,
  input  logic [WORD_W-1:0] rx_word,
  input  logic [WORD_W-1:0] exp_word,
  output logic [WORD_W-1:0] miss_vec,
  output logic [CNT_W-1:0]  cnt_next,
  output logic              pass_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             bad_word;

  assign miss_vec = cmp_valid ? (rx_word ^ exp_word) : '0;
  assign bad_word = |miss_vec;

  always_comb begin
    if (!active)                         cnt_next = '0;
    else if (bad_word && cnt_q != CNT_MAX) cnt_next = cnt_q + 1'b1;
    else                                 cnt_next = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pass_q <= 1'b0;
    end else begin
      cnt_q <= cnt_next;
      if (!active)
        pass_q <= 1'b0;
      else if (last_word && cnt_next == '0)
        pass_q <= 1'b1;
    end
  end

endmodule

// File: rtl/bist_out_mux.sv
// Registered output selection shared by normal data and test reporting.
module bist_out_mux #(
  parameter int WORD_W = 24,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_en,
  input  logic              active,
  input  logic              err_mode,
  input  logic [WORD_W-1:0] rx_word,
  input  logic [WORD_W-1:0] miss_vec,
  input  logic [CNT_W-1:0]  cnt_next,
  output logic [WORD_W-1:0] out_q
);

  always_ff @(posedge clk) begin
    if (rst)           out_q <= '0;
    else if (!test_en) out_q <= rx_word;
    else if (!active)  out_q <= '0;
    else if (err_mode) out_q <= WORD_W'(cnt_next);
    else               out_q <= miss_vec;
  end

endmodule

// File: rtl/link_bist_checker.sv
module link_bist_checker #(
  parameter int WORD_W  = 24,
  parameter int CNT_W   = 8,
  parameter int ORD     = 7,
  parameter int TAP     = 6,
  parameter int RUN_LEN = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_en,
  input  logic              lock,
  input  logic              err_mode,
  input  logic [WORD_W-1:0] rx_word,
  output logic [WORD_W-1:0] out_bus,
  output logic              pass
);

  logic              active;
  logic              cmp_valid;
  logic              last_word;
  logic [WORD_W-1:0] exp_word;
  logic [WORD_W-1:0] miss_vec;
  logic [CNT_W-1:0]  cnt_next;

  assign active = test_en && lock;

  bist_sync #(
    .WORD_W  (WORD_W),
    .ORD     (ORD),
    .TAP     (TAP),
    .RUN_LEN (RUN_LEN)
  ) u_sync (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .rx_word   (rx_word),
    .cmp_valid (cmp_valid),
    .last_word (last_word),
    .exp_word  (exp_word)
  );

  bist_err_acc #(
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W)
  ) u_acc (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .cmp_valid (cmp_valid),
    .last_word (last_word),
    .rx_word   (rx_word),
    .exp_word  (exp_word),
    .miss_vec  (miss_vec),
    .cnt_next  (cnt_next),
    .pass_q    (pass)
  );

  bist_out_mux #(
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .test_en  (test_en),
    .active   (active),
    .err_mode (err_mode),
    .rx_word  (rx_word),
    .miss_vec (miss_vec),
    .cnt_next (cnt_next),
    .out_q    (out_bus)
  );

endmodule

// File: rtl/link_bist_sva.sv
module link_bist_sva #(
  parameter int WORD_W = 24,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              test_en,
  input logic              lock,
  input logic              err_mode,
  input logic [WORD_W-1:0] rx_word,
  input logic [WORD_W-1:0] out_bus,
  input logic              pass
);

  logic cnt_view;
  assign cnt_view = test_en && lock && err_mode;

  p_passthrough_r2: assert property (@(posedge clk) disable iff (rst)
    !test_en |=> (out_bus == $past(rx_word) && !pass));

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_view |=> (out_bus[WORD_W-1:CNT_W] == '0));

  p_cnt_monotonic_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt_view) && $past(cnt_view, 2))
      |-> (out_bus[CNT_W-1:0] >= $past(out_bus[CNT_W-1:0])));

  p_pass_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (pass && test_en && lock) |=> pass);

  p_unlocked_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (test_en && !lock) |=> (out_bus == '0 && !pass));

endmodule

bind link_bist_checker link_bist_sva #(
  .WORD_W (WORD_W),
  .CNT_W  (CNT_W)
) u_sva (
  .clk      (clk),
  .rst      (rst),
  .test_en  (test_en),
  .lock     (lock),
  .err_mode (err_mode),
  .rx_word  (rx_word),
  .out_bus  (out_bus),
  .pass     (pass)
);

// File: tb/link_bist_checker_tb.sv
`timescale 1ns/1ps
module link_bist_checker_tb;

  localparam int W   = 24;
  localparam int RUN = 1024;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          test_en = 1'b0;
  logic          lock = 1'b0;
  logic          err_mode = 1'b0;
  logic [W-1:0]  rx_word = '0;
  logic [W-1:0]  out_bus;
  logic          pass;

  int n_chk  = 0;
  int n_fail = 0;

  // bench model of the sequence: hist[0] oldest bit, hist[6] newest
  bit [6:0] hist;
  int       m_cmp;
  int       m_err;
  bit       m_pass;

  always #10 clk = ~clk;

  link_bist_checker u_dut (
    .clk      (clk),
    .rst      (rst),
    .test_en  (test_en),
    .lock     (lock),
    .err_mode (err_mode),
    .rx_word  (rx_word),
    .out_bus  (out_bus),
    .pass     (pass)
  );

  function automatic logic [W-1:0] gen_word();
    logic [W-1:0] w;
    bit b;
    for (int k = 0; k < W; k++) begin
      b = hist[0] ^ hist[1];
      w[W-1-k] = b;
      hist = {b, hist[6:1]};
    end
    return w;
  endfunction

  task automatic check_bus(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s out_bus actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_pass(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s pass actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, sample at next fall
  task automatic cycle(logic [W-1:0] w);
    rx_word = w;
    @(negedge clk);
  endtask

  task automatic model_clear();
    m_cmp = 0; m_err = 0; m_pass = 1'b0;
  endtask

  task automatic send_idle(string req);
    cycle($urandom & 24'hFFFF80);
    check_bus(req, out_bus, '0);
    check_pass(req, pass, 1'b0);
  endtask

  task automatic send_seed(string req);
    cycle(gen_word());
    model_clear();
    check_bus(req, out_bus, '0);
    check_pass(req, pass, 1'b0);
  endtask

  task automatic send_cmp(string req, logic [W-1:0] mask);
    logic [W-1:0] exp;
    cycle(gen_word() ^ mask);
    m_cmp++;
    if (mask != '0 && m_err < 255) m_err++;
    if (m_cmp == RUN && m_err == 0) m_pass = 1'b1;
    exp = err_mode ? W'(m_err) : mask;
    check_bus(req, out_bus, exp);
    check_pass(req, pass, m_pass);
  endtask

  task automatic new_phase();
    hist = 7'($urandom_range(1, 127));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0421));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check_bus("R1", out_bus, '0);
    check_pass("R1", pass, 1'b0);

    // R2: transparent path
    for (int i = 0; i < 20; i++) begin
      logic [W-1:0] w;
      w = W'($urandom);
      lock = 1'($urandom);
      cycle(w);
      check_bus("R2", out_bus, w);
      check_pass("R2", pass, 1'b0);
    end

    // R9: enabled without lock
    test_en = 1'b1; lock = 1'b0;
    for (int i = 0; i < 5; i++) begin
      cycle(W'($urandom));
      check_bus("R9", out_bus, '0);
      check_pass("R9", pass, 1'b0);
    end

    // R3, R4, R5, R7: flag mode
    lock = 1'b1; err_mode = 1'b0;
    new_phase();
    for (int i = 0; i < 4; i++) send_idle("R3");
    send_seed("R3");
    send_cmp("R5", 24'hFFFFFF);
    send_cmp("R5", 24'h800000);
    send_cmp("R5", 24'h000001);
    send_cmp("R7", 24'h000000);
    for (int i = 0; i < 196; i++) begin
      logic [W-1:0] mk;
      mk = ($urandom_range(0, 3) == 0) ? W'($urandom) : '0;
      send_cmp("R5", mk);
    end

    // R6: switch to count view mid-run, then saturate
    err_mode = 1'b1;
    for (int i = 0; i < 300; i++) send_cmp("R6", W'(1) << $urandom_range(0, W - 1));
    // R8: failing run completes without pass
    for (int i = 0; i < 600; i++) send_cmp("R8", '0);

    // R9 + R10: leave test, come back at a new phase, clean run
    test_en = 1'b0;
    cycle(24'h123456);
    check_bus("R9", out_bus, 24'h123456);
    check_pass("R9", pass, 1'b0);
    test_en = 1'b1;
    new_phase();
    send_idle("R3");
    send_seed("R10");
    for (int i = 0; i < RUN; i++) send_cmp("R8", '0);
    for (int i = 0; i < 3; i++) send_cmp("R8", 24'h000400);

    // R9: lock drop clears count and pass
    lock = 1'b0;
    cycle(W'($urandom));
    check_bus("R9", out_bus, '0);
    check_pass("R9", pass, 1'b0);
    lock = 1'b1;
    new_phase();
    send_seed("R10");
    for (int i = 0; i < RUN + 2; i++) send_cmp("R8", (i == 500) ? 24'h020000 : '0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule